// File: doc/BRIEF.md
# Mixing Demodulator with Decimate-by-80 CIC Filter

This block turns a stream of 16-bit samples into one demodulated value for every 80 samples it accepts. Inside the block, a 32-bit phase accumulator drives a quarter-wave sine lookup that produces a local reference. Each accepted sample is multiplied by the reference taken at the same step, which gives a full-precision signed product. A three-stage cascaded integrator-comb low-pass filter then smooths the product and decimates it by 80. The 51-bit filter result is truncated to its upper 32 bits and presented with a one-cycle strobe.

The block serves one channel of a lock-in style error-signal generator. A design with several channels places one copy per channel. Software or neighbouring logic sets the reference frequency through a phase increment, and sets the reference phase through a phase offset. With a constant input and a frozen phase, the settled output is the input times the reference times 80 cubed, shifted right by 19.

Top module: `demod_cic`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase accumulator, the filter state and the decimation count are cleared. After such an edge, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high for exactly one cycle for every 80 accepted samples. A sample is accepted on a clock edge where `s_valid` is high. With a periodic `s_valid` pattern, exactly 80 samples are accepted between two strobes.
- R3: A cycle with `s_valid` low has no effect on the phase, the filter or the decimation count. The output strobe spacing and the settled value depend only on the accepted samples.
- R4: The lookup address is `p = acc + phase_ofs`. Bits [31:30] of `p` give the quadrant and bits [29:22] give the index `i`. The table holds T[k] = round(32767·sin(π·k/512)) for k = 0..255. The reference is:
  - quadrant 0: T[i]
  - quadrant 1: T[256−i], or +32767 when i = 0
  - quadrant 2: −T[i]
  - quadrant 3: −T[256−i], or −32767 when i = 0
- R5: The accumulator `acc` adds `phase_inc` after each accepted sample. With `phase_inc` = 0x80000000 and `phase_ofs` = 0x40000000, the reference alternates between +32767 and −32767, and the settled output is 0.
- R6: The mixer product is signed and exact, and the filter uses wrap-around two's-complement arithmetic on 51 bits. For a constant input x with a frozen reference r, the settled output equals (x·r·512000) >>> 19 as a signed 32-bit value.
- R7: `out_data` changes only on a cycle in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Sample accepted on this edge when high |
| s_data | input | 16 | Signed input sample |
| phase_inc | input | 32 | Phase step added per accepted sample |
| phase_ofs | input | 32 | Phase offset added before lookup |
| out_valid | output | 1 | One-cycle strobe with each filtered result |
| out_data | output | 32 | Signed filtered result, upper 32 of 51 bits |

## Verification
A corrupted integrator or comb register leaves a permanent offset or a ramp in `out_data`. The same happens if an integrator ignores a valid sample. This error appears at the first strobe after the fault and does not settle away, so a settled-value check four to six strobes into each vector catches it. A miscounted decimation counter shows as strobes that are not 80 accepted samples apart, visible within two strobe periods. A wrong quadrant or mirror in the lookup shows as a wrong magnitude or sign of the settled value for the matching phase offset. A stuck phase accumulator shows as a nonzero result where the alternating reference should cancel to zero.

// File: rtl/demod_pkg.sv
// Shared helpers for the demodulator: reference table contents.
// Assumes elaboration-time evaluation of real math for table constants.
package demod_pkg;

    // Quarter-wave sine entry k of a 2**aw table, scaled to amp, rounded.
    function automatic int quarter_sine(input int k, input int aw, input int amp);
        real ang;
        ang = 3.14159265358979 * real'(k) / (2.0 * real'(2 ** aw));
        return $rtoi(real'(amp) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/demod_nco.sv
// Phase accumulator and quarter-wave sine lookup.
// Assumes the accumulator steps once per accepted sample; the reference
// output is combinational from (accumulator + offset).
module demod_nco #(
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 8,
    parameter int AMP_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic [PHASE_W-1:0]      inc,
    input  logic [PHASE_W-1:0]      ofs,
    output logic signed [AMP_W-1:0] ref_val
);
    localparam int DEPTH = 2 ** LUT_AW;
    localparam int AMP   = 2 ** (AMP_W - 1) - 1;

    logic [PHASE_W-1:0] acc;
    logic [PHASE_W-1:0] phase;
    logic [1:0]         quad;
    logic [LUT_AW-1:0]  idx;
    logic [LUT_AW-1:0]  mir;
    logic [AMP_W-1:0]   rom [DEPTH];
    logic [AMP_W-1:0]   mag;

    // Table constants computed at elaboration.
    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        localparam logic [AMP_W-1:0] VAL = AMP_W'(demod_pkg::quarter_sine(k, LUT_AW, AMP));
        assign rom[k] = VAL;
    end

    // Phase accumulator advances on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (step) acc <= acc + inc;
    end

    assign phase = acc + ofs;
    assign quad  = phase[PHASE_W-1 -: 2];
    assign idx   = phase[PHASE_W-3 -: LUT_AW];
    assign mir   = (~idx) + LUT_AW'(1);

    // Quadrant folding: mirror in odd quadrants, negate in the lower half.
    always_comb begin
        if (quad[0]) mag = (idx == '0) ? AMP_W'(AMP) : rom[mir];
        else         mag = rom[idx];
        ref_val = quad[1] ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/demod_cic_filt.sv
// Decimating CIC filter: STAGES pipelined integrators, decimation by
// DECIM, STAGES combs with differential delay 1, truncated output.
// Assumes wrap-around arithmetic; accumulator width covers DECIM**STAGES gain.
module demod_cic_filt #(
    parameter int IN_W   = 32,
    parameter int OUT_W  = 32,
    parameter int DECIM  = 80,
    parameter int STAGES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int ACC_W = IN_W + $clog2(DECIM ** STAGES);
    localparam int CNT_W = $clog2(DECIM);

    logic signed [ACC_W-1:0] integ [STAGES];
    logic signed [ACC_W-1:0] dly   [STAGES];
    logic signed [ACC_W-1:0] diff  [STAGES];
    logic [CNT_W-1:0]        cnt;
    logic                    fire;

    for (genvar s = 0; s < STAGES; s++) begin : g_int
        if (s == 0) begin : g_first
            // First integrator sums sign-extended input.
            always_ff @(posedge clk) begin
                if (!rst_n)        integ[s] <= '0;
                else if (in_valid) integ[s] <= integ[s] + ACC_W'(in_data);
            end
        end else begin : g_rest
            // Later integrators sum the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n)        integ[s] <= '0;
                else if (in_valid) integ[s] <= integ[s] + integ[s-1];
            end
        end
    end

    // Decimation counter marks every DECIM-th accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= in_valid && (cnt == CNT_W'(DECIM - 1));
            if (in_valid) cnt <= (cnt == CNT_W'(DECIM - 1)) ? '0 : cnt + 1'b1;
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_comb
        if (s == 0) begin : g_first
            assign diff[s] = integ[STAGES-1] - dly[s];
            // Comb delay holds the last decimated integrator value.
            always_ff @(posedge clk) begin
                if (!rst_n)    dly[s] <= '0;
                else if (fire) dly[s] <= integ[STAGES-1];
            end
        end else begin : g_rest
            assign diff[s] = diff[s-1] - dly[s];
            // Comb delay holds the last previous-stage difference.
            always_ff @(posedge clk) begin
                if (!rst_n)    dly[s] <= '0;
                else if (fire) dly[s] <= diff[s-1];
            end
        end
    end

    // Output register: truncated top bits with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_data <= diff[STAGES-1][ACC_W-1 -: OUT_W];
        end
    end
endmodule

// File: rtl/demod_cic.sv
// One demodulation channel: reference generator, registered mixer, CIC.
// Assumes a synchronous active-low reset; one instance per channel.
module demod_cic #(
    parameter int DATA_W  = 16,
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 8,
    parameter int DECIM   = 80,
    parameter int STAGES  = 3,
    parameter int OUT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic [DATA_W-1:0]  s_data,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic [PHASE_W-1:0] phase_ofs,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [DATA_W-1:0] ref_val;
    logic signed [DATA_W-1:0] samp_a;
    logic signed [DATA_W-1:0] ref_a;
    logic                     va;
    logic signed [PROD_W-1:0] mix_prod;
    logic                     mix_valid;
    logic signed [OUT_W-1:0]  filt_out;

    demod_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(DATA_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .step(s_valid),
        .inc(phase_inc), .ofs(phase_ofs), .ref_val(ref_val)
    );

    // Align sample with its reference value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= '0;
            ref_a  <= '0;
            va     <= 1'b0;
        end else begin
            samp_a <= $signed(s_data);
            ref_a  <= ref_val;
            va     <= s_valid;
        end
    end

    // Registered full-precision signed multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_prod  <= '0;
            mix_valid <= 1'b0;
        end else begin
            mix_prod  <= samp_a * ref_a;
            mix_valid <= va;
        end
    end

    demod_cic_filt #(.IN_W(PROD_W), .OUT_W(OUT_W), .DECIM(DECIM), .STAGES(STAGES)) u_cic (
        .clk(clk), .rst_n(rst_n), .in_valid(mix_valid), .in_data(mix_prod),
        .out_valid(out_valid), .out_data(filt_out)
    );

    assign out_data = filt_out;
endmodule

// File: rtl/demod_cic_chk.sv
// Temporal checks on the demodulator ports and mixer handoff.
module demod_cic_chk #(
    parameter int DECIM = 80,
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_valid,
    input logic             mix_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    int seen;

    // Count accepted samples since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || out_valid) seen <= 0;
        else if (s_valid)        seen <= seen + 1;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2
    AST_STROBE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= DECIM + 3); // R2
    AST_IDLE_NO_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> ##1 !mix_valid); // R3
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid); // R7
endmodule

bind demod_cic demod_cic_chk #(.DECIM(DECIM), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .mix_valid(mix_valid),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/demod_cic_test.sv
module demod_cic_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic [15:0] s_data = '0;
    logic [31:0] phase_inc = '0;
    logic [31:0] phase_ofs = '0;
    logic        out_valid;
    logic [31:0] out_data;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    demod_cic uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .phase_inc(phase_inc), .phase_ofs(phase_ofs),
        .out_valid(out_valid), .out_data(out_data)
    );

    // {sample, phase offset, expected reference per R4}
    typedef struct packed { logic [15:0] x; logic [31:0] ofs; logic [15:0] r; } vec_t;
    localparam vec_t VECS [8] = '{
        '{16'd1000,   32'h4000_0000, 16'd32767},
        '{-16'sd20000, 32'h4000_0000, 16'd32767},
        '{16'd12345,  32'hC000_0000, -16'sd32767},
        '{16'd30000,  32'h8000_0000, 16'd0},
        '{-16'sd32768, 32'h2000_0000, 16'd23170},
        '{16'd500,    32'hA000_0000, -16'sd23170},
        '{16'd32767,  32'h6000_0000, 16'd23170},
        '{-16'sd7,    32'h0000_0000, 16'd0}
    };

    function automatic logic [31:0] settled(input logic [15:0] x, input logic [15:0] r);
        longint p;
        p = longint'($signed(x)) * longint'($signed(r));
        return 32'((p * 64'sd512000) >>> 19);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic wait_strobes(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            if (out_valid) got++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 out_data", out_data, 32'd0);
        rst_n = 1'b1;

        // R4/R6: table walk with frozen phase and continuous samples.
        s_valid = 1'b1;
        for (int v = 0; v < 8; v++) begin
            s_data    = VECS[v].x;
            phase_ofs = VECS[v].ofs;
            wait_strobes(6);
            check($sformatf("R6/R4 vec%0d", v), out_data, settled(VECS[v].x, VECS[v].r));
        end

        // R5: alternating reference cancels.
        s_data    = 16'd20000;
        phase_ofs = 32'h4000_0000;
        phase_inc = 32'h8000_0000;
        wait_strobes(6);
        check("R5 alternating", out_data, 32'd0);

        // R1: reset mid-run clears outputs.
        @(negedge clk);
        rst_n = 1'b0;
        s_valid = 1'b0;
        phase_inc = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset out_data", out_data, 32'd0);
        rst_n = 1'b1;

        // R2/R3: gapped valid pattern, 80 accepted between strobes.
        begin
            int cyc = 0;
            int acc = 0;
            int strobes = 0;
            s_data = 16'd4321;
            phase_ofs = 32'hC000_0000;
            while (strobes < 7) begin
                @(negedge clk);
                if (out_valid) begin
                    strobes++;
                    if (strobes >= 3) check("R2 gap spacing", 32'(acc), 32'd80);
                    if (strobes >= 6) check("R3 gap value", out_data, settled(16'd4321, -16'sd32767));
                    acc = 0;
                end
                s_valid = (cyc % 3) != 0;
                if (s_valid) acc++;
                cyc++;
            end
            @(negedge clk);
            check("R2 single-cycle strobe", {31'd0, out_valid}, 32'd0);
        end

        // R3: idle input leaves output held and no strobe.
        begin
            logic [31:0] held;
            int extra = 0;
            s_valid = 1'b0;
            held = out_data;
            repeat (300) begin
                @(negedge clk);
                if (out_valid) extra++;
            end
            check("R3 idle no strobe", 32'(extra), 32'd0);
            check("R3 idle held", out_data, held);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule